// File: doc/BRIEF.md
# Super I/O Resource Decoder

This block sits on an 8-bit I/O bus and owns the address and interrupt assignment of one parallel port and two serial ports. Software reaches it through an index/data pair: it writes a register number to the index port at 0x398, then reads or writes that register through the data port at 0x399. Three configuration registers exist. The first holds an enable per port. The second holds packed selection codes that choose each port's base address from a small fixed table. The third is stored and can be read back but drives no mapping.

From the current mapping the block decodes the incoming 16-bit I/O address into one chip select per port. It also reports the interrupt line number each port uses, so the interrupt router can steer it. The serial and parallel cores themselves sit outside this block. After reset the registers read as zero, but a default mapping with all three ports enabled stays in force until the first write lands in a real register.

Top module: `sio_resource_map`

## Requirements
- R1: A write to port 0x398 loads the full 8-bit value into the index register, and a read of 0x398 returns that value. The index resets to 0.
- R2: With index 0, 1 or 2, a write to port 0x399 stores the byte in that register, and a read of 0x399 returns it.
- R3: With an index of 3 or above, a read of 0x399 returns 0xFF. A write to 0x399 changes no register and changes no mapping output.
- R4: `ioRdData` is 0xFF whenever `ioRd` is low or the address is neither 0x398 nor 0x399.
- R5: After reset, and until the first write that stores into a register, all three ports are enabled with serial A at 0x3F8 (IRQ 4), serial B at 0x2F8 (IRQ 3) and the parallel port at 0x378 (IRQ 7). During that time every register still reads 0.
- R6: Once any write to 0x399 has stored into a register, all enables, bases and IRQs come from the registers for the rest of the run, and every later stored write takes effect on the next cycle.
- R7: Register 0 bit 0 enables the parallel port, bit 1 enables serial A and bit 2 enables serial B. A disabled port has its enable output low and its chip select never asserts.
- R8: Register 1 bits 1:0 pick the parallel base: code 0 gives 0x378, code 1 gives 0x3BC, code 2 gives 0x278 and code 3 gives 0x378.
- R9: Register 1 bits 3:2 pick the serial A base and bits 5:4 pick the serial B base. For each, code 0 gives 0x3F8, code 1 gives 0x2F8, code 2 gives 0x3E8 and code 3 gives 0x2E8.
- R10: Serial A always reports IRQ 4 and serial B always reports IRQ 3.
- R11: The parallel port reports IRQ 5 when its code is 3 or its base is 0x278, and IRQ 7 in every other case.
- R12: A serial chip select asserts for the eight addresses from base to base+7. The parallel chip select asserts for the four addresses from base to base+3, including the window at 0x3BC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address |
| ioWrData | input | 8 | Write data |
| ioRd | input | 1 | Read strobe, one cycle per access |
| ioWr | input | 1 | Write strobe, one cycle per access |
| ioRdData | output | 8 | Read data, combinational during ioRd |
| parCs | output | 1 | Parallel port chip select |
| serACs | output | 1 | Serial A chip select |
| serBCs | output | 1 | Serial B chip select |
| parIrq | output | 4 | Parallel interrupt line number |
| serAIrq | output | 4 | Serial A interrupt line number |
| serBIrq | output | 4 | Serial B interrupt line number |
| parEn | output | 1 | Parallel port enabled |
| serAEn | output | 1 | Serial A enabled |
| serBEn | output | 1 | Serial B enabled |

## Verification
The assertions assume that a bus master never raises `ioRd` and `ioWr` in the same cycle. They also assume that each strobe lasts exactly one clock and that `ioAddr` and `ioWrData` are steady while a strobe is high. The bench keeps to this by driving every input on the falling edge and issuing one access at a time. Between accesses it lowers both strobes and moves only the address. It uses those address sweeps to probe the chip-select windows, and samples the combinational outputs one nanosecond after each change.

// File: rtl/sio_map_pkg.sv
package sio_map_pkg;

  localparam int IO_ADDR_W = 16;
  localparam int IO_DATA_W = 8;
  localparam int IRQ_W     = 4;

  typedef struct packed {
    logic idxWr;
    logic dataWr;
    logic idxRd;
    logic dataRd;
  } busStb_t;

  // parallel base choice, reg1[1:0]
  function automatic logic [IO_ADDR_W-1:0] parBaseOf(input logic [1:0] code);
    case (code)
      2'd1:    return 16'h03BC;
      2'd2:    return 16'h0278;
      default: return 16'h0378;
    endcase
  endfunction

  // serial base choice, shared by both serial fields
  function automatic logic [IO_ADDR_W-1:0] serBaseOf(input logic [1:0] code);
    case (code)
      2'd0:    return 16'h03F8;
      2'd1:    return 16'h02F8;
      2'd2:    return 16'h03E8;
      default: return 16'h02E8;
    endcase
  endfunction

endpackage

// File: rtl/sio_win_match.sv
module sio_win_match #(
  parameter int ADDR_W = 16,
  parameter int WIN    = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              enable,
  output logic              hit
);
  localparam int LOW_W = $clog2(WIN);

  always_comb hit = enable && (addr[ADDR_W-1:LOW_W] == base[ADDR_W-1:LOW_W]);
endmodule

// File: rtl/sio_map_ctrl.sv
module sio_map_ctrl
  import sio_map_pkg::*;
#(
  parameter logic [IO_ADDR_W-1:0] INDEX_PORT = 16'h0398,
  parameter logic [IO_ADDR_W-1:0] DATA_PORT  = 16'h0399
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IO_ADDR_W-1:0] ioAddr,
  input  logic                 ioRd,
  input  logic                 ioWr,
  output busStb_t              stb
);
  logic atIndex;
  logic atData;

  always_comb begin
    atIndex    = (ioAddr == INDEX_PORT);
    atData     = (ioAddr == DATA_PORT);
    stb.idxWr  = ioWr && atIndex;
    stb.dataWr = ioWr && atData;
    stb.idxRd  = ioRd && atIndex;
    stb.dataRd = ioRd && atData;
  end

  // R1 R2: at most one register-file access strobe per cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(ioRd && ioWr) |-> $onehot0(stb));
endmodule

// File: rtl/sio_map_dp.sv
module sio_map_dp
  import sio_map_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int SER_WIN  = 8,
  parameter int PAR_WIN  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  busStb_t              stb,
  input  logic [IO_ADDR_W-1:0] ioAddr,
  input  logic [IO_DATA_W-1:0] ioWrData,
  output logic [IO_DATA_W-1:0] ioRdData,
  output logic                 parCs,
  output logic                 serACs,
  output logic                 serBCs,
  output logic [IRQ_W-1:0]     parIrq,
  output logic [IRQ_W-1:0]     serAIrq,
  output logic [IRQ_W-1:0]     serBIrq,
  output logic                 parEn,
  output logic                 serAEn,
  output logic                 serBEn
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int NUM_SER = 2;

  logic [IO_DATA_W-1:0] idxReg;
  logic [IO_DATA_W-1:0] cfgReg [NUM_REGS];
  logic                 configured;
  logic                 idxOk;
  logic [IDX_W-1:0]     idxSel;

  always_comb begin
    idxOk  = (idxReg < IO_DATA_W'(NUM_REGS));
    idxSel = idxReg[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idxReg     <= '0;
      configured <= 1'b0;
    end else begin
      if (stb.idxWr) idxReg <= ioWrData;
      if (stb.dataWr && idxOk) configured <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) cfgReg[g] <= '0;
      else if (stb.dataWr && idxOk && (idxSel == IDX_W'(g))) cfgReg[g] <= ioWrData;
    end
  end

  always_comb begin
    if (stb.idxRd)                ioRdData = idxReg;
    else if (stb.dataRd && idxOk) ioRdData = cfgReg[idxSel];
    else                          ioRdData = '1;
  end

  // active mapping
  logic [1:0]           parCode;
  logic [IO_ADDR_W-1:0] parBase;
  logic [IO_ADDR_W-1:0] serBase [NUM_SER];
  logic [NUM_SER-1:0]   serEnVec;
  logic [NUM_SER-1:0]   serHit;

  always_comb begin
    if (!configured) begin
      parEn      = 1'b1;
      serEnVec   = '1;
      parCode    = 2'd0;
      parBase    = 16'h0378;
      serBase[0] = 16'h03F8;
      serBase[1] = 16'h02F8;
    end else begin
      parEn      = cfgReg[0][0];
      serEnVec   = cfgReg[0][2:1];
      parCode    = cfgReg[1][1:0];
      parBase    = parBaseOf(parCode);
      serBase[0] = serBaseOf(cfgReg[1][3:2]);
      serBase[1] = serBaseOf(cfgReg[1][5:4]);
    end
    parIrq  = ((parCode == 2'd3) || (parBase == 16'h0278)) ? IRQ_W'(5) : IRQ_W'(7);
    serAIrq = IRQ_W'(4);
    serBIrq = IRQ_W'(3);
    serAEn  = serEnVec[0];
    serBEn  = serEnVec[1];
  end

  for (genvar s = 0; s < NUM_SER; s++) begin : g_ser
    sio_win_match #(.ADDR_W(IO_ADDR_W), .WIN(SER_WIN)) u_win (
      .addr(ioAddr), .base(serBase[s]), .enable(serEnVec[s]), .hit(serHit[s]));
  end

  sio_win_match #(.ADDR_W(IO_ADDR_W), .WIN(PAR_WIN)) u_parWin (
    .addr(ioAddr), .base(parBase), .enable(parEn), .hit(parCs));

  always_comb begin
    serACs = serHit[0];
    serBCs = serHit[1];
  end

  a_r1_index_capture: assert property (@(posedge clk) disable iff (!rst_n)
    stb.idxWr |=> idxReg == $past(ioWrData));

  a_r3_high_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.dataWr && !idxOk) |=> $stable(configured) && $stable(cfgReg[0]) && $stable(cfgReg[1]));

  a_r6_config_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    configured |=> configured);

  a_r7_cs_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!parCs || parEn) && (!serACs || serAEn) && (!serBCs || serBEn));

  a_r11_par_irq_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (parIrq == IRQ_W'(5)) || (parIrq == IRQ_W'(7)));
endmodule

// File: rtl/sio_resource_map.sv
module sio_resource_map
  import sio_map_pkg::*;
#(
  parameter logic [IO_ADDR_W-1:0] INDEX_PORT = 16'h0398,
  parameter logic [IO_ADDR_W-1:0] DATA_PORT  = 16'h0399,
  parameter int NUM_REGS = 3,
  parameter int SER_WIN  = 8,
  parameter int PAR_WIN  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ioAddr,
  input  logic [7:0]  ioWrData,
  input  logic        ioRd,
  input  logic        ioWr,
  output logic [7:0]  ioRdData,
  output logic        parCs,
  output logic        serACs,
  output logic        serBCs,
  output logic [3:0]  parIrq,
  output logic [3:0]  serAIrq,
  output logic [3:0]  serBIrq,
  output logic        parEn,
  output logic        serAEn,
  output logic        serBEn
);
  busStb_t stb;

  sio_map_ctrl #(.INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr), .stb(stb));

  sio_map_dp #(.NUM_REGS(NUM_REGS), .SER_WIN(SER_WIN), .PAR_WIN(PAR_WIN)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .parCs(parCs), .serACs(serACs), .serBCs(serBCs),
    .parIrq(parIrq), .serAIrq(serAIrq), .serBIrq(serBIrq),
    .parEn(parEn), .serAEn(serAEn), .serBEn(serBEn));
endmodule

// File: tb/sio_resource_map_tb.sv
module sio_resource_map_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] ioAddr = 16'h0;
  logic [7:0]  ioWrData = 8'h0;
  logic ioRd = 1'b0;
  logic ioWr = 1'b0;
  logic [7:0] ioRdData;
  logic parCs, serACs, serBCs, parEn, serAEn, serBEn;
  logic [3:0] parIrq, serAIrq, serBIrq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sio_resource_map dut_i (
    .clk(clk), .rst_n(rst_n), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioRd(ioRd),
    .ioWr(ioWr), .ioRdData(ioRdData), .parCs(parCs), .serACs(serACs), .serBCs(serBCs),
    .parIrq(parIrq), .serAIrq(serAIrq), .serBIrq(serBIrq),
    .parEn(parEn), .serAEn(serAEn), .serBEn(serBEn));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(input int a, input int d);
    @(negedge clk);
    ioAddr = 16'(a); ioWrData = 8'(d); ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic busRd(input int a, output int d);
    @(negedge clk);
    ioAddr = 16'(a); ioRd = 1'b1;
    #1 d = int'(ioRdData);
    ioRd = 1'b0;
  endtask

  task automatic setReg(input int idx, input int d);
    busWr(16'h398, idx);
    busWr(16'h399, d);
  endtask

  function automatic int parBaseExp(input int c);
    return (c == 1) ? 'h3BC : (c == 2) ? 'h278 : 'h378;
  endfunction

  function automatic int serBaseExp(input int c);
    return (c[0] ? 'h2F8 : 'h3F8) - (c[1] ? 'h10 : 0);
  endfunction

  // which: 0 parallel, 1 serial A, 2 serial B
  task automatic winSweep(input string tag, input int which, input int base, input int win, input bit en);
    for (int a = base - 1; a <= base + win; a++) begin
      @(negedge clk);
      ioAddr = 16'(a);
      #1;
      chk(tag, (which == 0) ? int'(parCs) : (which == 1) ? int'(serACs) : int'(serBCs),
          (en && a >= base && a < base + win) ? 1 : 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5 reset state
    busRd(16'h398, d); chk("R1 reset index", d, 0);
    busRd(16'h399, d); chk("R5 reg0 reads zero", d, 0);
    chk("R5 enables", {parEn, serAEn, serBEn}, 3'b111);
    chk("R5 par irq", parIrq, 7);
    chk("R10 serA irq", serAIrq, 4);
    chk("R10 serB irq", serBIrq, 3);
    winSweep("R5 serA default", 1, 'h3F8, 8, 1);
    winSweep("R5 serB default", 2, 'h2F8, 8, 1);
    winSweep("R5 par default", 0, 'h378, 4, 1);

    // R1 index readback, R3 high index
    busWr(16'h398, 8'hC3); busRd(16'h398, d); chk("R1 index readback", d, 'hC3);
    busRd(16'h399, d); chk("R3 high index read", d, 'hFF);
    busWr(16'h398, 3); busRd(16'h399, d); chk("R3 index 3 read", d, 'hFF);
    busWr(16'h399, 8'h00);
    chk("R3 high write keeps default", {parEn, serAEn, serBEn}, 3'b111);
    winSweep("R3 serB after high write", 2, 'h2F8, 8, 1);
    busWr(16'h398, 0); busRd(16'h399, d); chk("R3 reg0 untouched", d, 0);

    // R4 undecoded / no strobe
    busRd(16'h039A, d); chk("R4 undecoded", d, 'hFF);
    busRd(16'h0000, d); chk("R4 undecoded zero", d, 'hFF);
    @(negedge clk); ioAddr = 16'h398; #1; chk("R4 no strobe", ioRdData, 'hFF);

    // R6 first stored write switches to register mapping
    setReg(2, 'hA5);
    chk("R6 enables from regs", {parEn, serAEn, serBEn}, 3'b000);
    winSweep("R6 serA off", 1, 'h3F8, 8, 0);
    busRd(16'h399, d); chk("R2 reg2 readback", d, 'hA5);

    // R7 enable sweep
    for (int e = 0; e < 8; e++) begin
      setReg(0, e);
      busRd(16'h399, d); chk("R2 reg0 readback", d, e);
      chk("R7 par en", parEn, e & 1);
      chk("R7 serA en", serAEn, (e >> 1) & 1);
      chk("R7 serB en", serBEn, (e >> 2) & 1);
      winSweep("R7 par cs", 0, 'h378, 4, e[0]);
      winSweep("R7 serA cs", 1, 'h3F8, 8, e[1]);
      winSweep("R7 serB cs", 2, 'h3F8, 8, e[2]);
    end

    // R8 R9 R11 R12 code sweep, all enabled
    setReg(0, 7);
    for (int c = 0; c < 64; c++) begin
      int pc, pb;
      setReg(1, c);
      busRd(16'h399, d); chk("R2 reg1 readback", d, c);
      pc = c & 3;
      pb = parBaseExp(pc);
      winSweep("R8 R12 par window", 0, pb, 4, 1);
      winSweep("R9 R12 serA window", 1, serBaseExp((c >> 2) & 3), 8, 1);
      winSweep("R9 R12 serB window", 2, serBaseExp((c >> 4) & 3), 8, 1);
      chk("R11 par irq", parIrq, (pc == 3 || pb == 'h278) ? 5 : 7);
      chk("R10 serA irq", serAIrq, 4);
      chk("R10 serB irq", serBIrq, 3);
    end

    // R3 high-index write after config leaves mapping alone
    busWr(16'h398, 8'h80); busWr(16'h399, 8'h00);
    chk("R3 mapping kept", {parEn, serAEn, serBEn}, 3'b111);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule